// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Sequencer

This unit sits behind an instruction decoder in an 8-bit processor core. Once the opcode byte has been fetched and decoded into a mode code, a `start` pulse hands the unit the mode, the current program counter and the two index registers. The unit then walks the byte-wide bus, one access per cycle. It collects the instruction's operand bytes at the program counter and forms the effective address. Zero-page pointers are fetched when the mode calls for them, and dummy reads at the program counter are issued where each mode places them. When it finishes it raises `done` for one cycle. At that point it presents the advanced program counter, up to three 16-bit results and an immediate byte. These stay valid until the next accepted `start`.

The sequencer is built around one state machine with these states: IDLE, IMMED (immediate byte of a test mode), LO and HI (low and high byte at the program counter), PTR (zero-page pointer byte), PDUM (dummy read after the pointer byte), PLO and PHI (pointer bytes read from the zero page), DUMMY (dummy read at the program counter) and DONE. Every mode starts from IDLE on an accepted `start`:
- IDLE goes to DUMMY for implied modes, to PTR for indirect modes, to IMMED for immediate-test modes, and to LO for all other modes.
- IMMED always goes to LO.
- LO goes to DONE for one-byte modes and to DUMMY for zero-page modes. Otherwise it goes to HI.
- HI returns to LO while block words remain. After that it goes to DUMMY or to DONE, depending on the mode.
- The indirect modes run PTR, PDUM, PLO, PHI and then DUMMY.
- DUMMY always goes to DONE, and DONE always returns to IDLE.

Top module: `opfetch_seq`

## Requirements
- R1: After reset, `bus_rd` and `done` are low and `pc_out`, `opnd_a`, `opnd_b`, `opnd_c` and `imm_byte` are all zero.
- R2: `start` is taken only in IDLE. At that point the unit latches the mode, PC, X and Y, and it ignores `start` and input changes until it is back in IDLE. `done` is a one-cycle pulse that comes 2 to 7 cycles after the accepting edge, and the results hold until the next accepted start. Result fields that a mode does not write read as zero.
- R3: Mode 0 (implied or accumulator) makes exactly one read, a dummy read at PC. It returns `opnd_a` = 0 and leaves PC unchanged.
- R4: Mode 1 (immediate or relative) reads one byte at PC, returns it zero-extended in `opnd_a`, and advances PC by one.
- R5: Modes 2, 3 and 4 (zero page, zero page plus X, zero page plus Y) read one byte at PC. They return ZP_BASE plus the 8-bit sum of that byte and the index (none, X or Y), with the sum wrapping modulo 256. A dummy read at the advanced PC follows.
- R6: Modes 5, 6 and 7 (absolute, absolute plus X, absolute plus Y) read a little-endian word at PC and PC+1. They return the word plus the index (none, X or Y) modulo 65536, and then do a dummy read at the advanced PC.
- R7: Mode 8 (word operand, used for zero-page-relative and jump-indirect operands) reads a little-endian word at PC. It returns the word unchanged and issues no dummy read.
- R8: Mode 9 (block) reads three little-endian words in a row at PC and returns them in `opnd_a` (source), `opnd_b` (destination) and `opnd_c` (length). It issues no dummy read and advances PC by six.
- R9: Modes 10, 11, 12 and 13 (test with zero page, zero page plus X, absolute, absolute plus X) first read the immediate byte into `imm_byte`. They then form the address into `opnd_a` as in R5 or R6, and finish with a dummy read at PC.
- R10: Modes 14, 15 and 16 (zero-page indirect, pre-indexed by X, post-indexed by Y) run this sequence:
  - read the pointer byte at PC;
  - dummy read at PC;
  - read the pointer low byte at ZP_BASE plus the pointer, then the high byte at the next zero-page offset;
  - dummy read at PC.

  Mode 15 adds X to the pointer byte modulo 256. Mode 16 adds Y to the fetched 16-bit pointer modulo 65536.
- R11: When the pointer offset in effect is 8'hFF, the high pointer byte is read from ZP_BASE plus 8'h00, not from ZP_BASE plus 16'h100.
- R12: There is at most one bus read per cycle and none in the IDLE or DONE cycles. Every read that is not at the current PC falls within the 256 bytes starting at ZP_BASE. Between accepted starts, `pc_out` only holds or steps up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch sequence (taken in IDLE only) |
| mode | input | 5 | Addressing-mode code (see R3 to R10) |
| pc_in | input | AW | Program counter pointing at the first operand byte |
| x_in | input | DW | X index register |
| y_in | input | DW | Y index register |
| rd_data | input | DW | Bus read data, valid in the cycle of the access |
| bus_addr | output | AW | Bus address of the current access |
| bus_rd | output | 1 | Bus read strobe |
| pc_out | output | AW | Program counter after the operand bytes |
| done | output | 1 | One-cycle completion pulse |
| opnd_a | output | AW | First result: effective address, immediate or block source |
| opnd_b | output | AW | Second result: block destination |
| opnd_c | output | AW | Third result: block length |
| imm_byte | output | DW | Immediate byte of the test modes |

## Verification
The assertions assume that read data is returned combinationally in the same cycle as the access. They also take as given that `start` is raised only with a mode code in the range 0 to 16 and stays quiet until the run is over, apart from deliberate intrusions. The stimulus drives inputs on the falling edge and serves reads from a memory model that is computed per address, with a small override table. It forces pointer bytes of 8'hFF and index sums that wrap, and it places a distinct decoy value at ZP_BASE plus 16'h100. One scenario pulses `start` with different inputs partway through a block fetch, to show that the intrusion has no effect.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam int MODE_W = 5;
    localparam int NWORD  = 3;
    localparam int WIDX_W = $clog2(NWORD);

    localparam logic [MODE_W-1:0] MODE_IMPL  = 5'd0;
    localparam logic [MODE_W-1:0] MODE_IMM   = 5'd1;
    localparam logic [MODE_W-1:0] MODE_ZP    = 5'd2;
    localparam logic [MODE_W-1:0] MODE_ZPX   = 5'd3;
    localparam logic [MODE_W-1:0] MODE_ZPY   = 5'd4;
    localparam logic [MODE_W-1:0] MODE_ABS   = 5'd5;
    localparam logic [MODE_W-1:0] MODE_ABSX  = 5'd6;
    localparam logic [MODE_W-1:0] MODE_ABSY  = 5'd7;
    localparam logic [MODE_W-1:0] MODE_WORD  = 5'd8;
    localparam logic [MODE_W-1:0] MODE_BLOCK = 5'd9;
    localparam logic [MODE_W-1:0] MODE_IZP   = 5'd10;
    localparam logic [MODE_W-1:0] MODE_IZPX  = 5'd11;
    localparam logic [MODE_W-1:0] MODE_IABS  = 5'd12;
    localparam logic [MODE_W-1:0] MODE_IABSX = 5'd13;
    localparam logic [MODE_W-1:0] MODE_ZIND  = 5'd14;
    localparam logic [MODE_W-1:0] MODE_INDX  = 5'd15;
    localparam logic [MODE_W-1:0] MODE_INDY  = 5'd16;

    typedef enum logic [2:0] {
        AK_NONE, AK_BYTE, AK_ZP, AK_ABS, AK_WORD, AK_BLOCK, AK_IND
    } addr_kind_e;

    typedef enum logic [1:0] {
        IX_NONE, IX_X, IX_Y
    } idx_sel_e;

    typedef struct packed {
        addr_kind_e kind;
        idx_sel_e   idx;
        logic       has_imm;
        logic       post_idx;
        logic       dummy_end;
    } mode_info_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IMMED, ST_LO, ST_HI, ST_PTR,
        ST_PDUM, ST_PLO, ST_PHI, ST_DUMMY, ST_DONE
    } fsm_e;

endpackage

// File: rtl/opf_mode_dec.sv
module opf_mode_dec
    import opf_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output mode_info_t        info
);

    always_comb begin
        info = '{kind: AK_NONE, idx: IX_NONE, has_imm: 1'b0,
                 post_idx: 1'b0, dummy_end: 1'b0};
        case (code)
            MODE_IMPL:  info.kind = AK_NONE;
            MODE_IMM:   info.kind = AK_BYTE;
            MODE_ZP:    begin info.kind = AK_ZP;  info.dummy_end = 1'b1; end
            MODE_ZPX:   begin info.kind = AK_ZP;  info.idx = IX_X; info.dummy_end = 1'b1; end
            MODE_ZPY:   begin info.kind = AK_ZP;  info.idx = IX_Y; info.dummy_end = 1'b1; end
            MODE_ABS:   begin info.kind = AK_ABS; info.dummy_end = 1'b1; end
            MODE_ABSX:  begin info.kind = AK_ABS; info.idx = IX_X; info.dummy_end = 1'b1; end
            MODE_ABSY:  begin info.kind = AK_ABS; info.idx = IX_Y; info.dummy_end = 1'b1; end
            MODE_WORD:  info.kind = AK_WORD;
            MODE_BLOCK: info.kind = AK_BLOCK;
            MODE_IZP:   begin info.kind = AK_ZP;  info.has_imm = 1'b1; info.dummy_end = 1'b1; end
            MODE_IZPX:  begin info.kind = AK_ZP;  info.has_imm = 1'b1; info.idx = IX_X;
                              info.dummy_end = 1'b1; end
            MODE_IABS:  begin info.kind = AK_ABS; info.has_imm = 1'b1; info.dummy_end = 1'b1; end
            MODE_IABSX: begin info.kind = AK_ABS; info.has_imm = 1'b1; info.idx = IX_X;
                              info.dummy_end = 1'b1; end
            MODE_ZIND:  begin info.kind = AK_IND; info.dummy_end = 1'b1; end
            MODE_INDX:  begin info.kind = AK_IND; info.idx = IX_X; info.dummy_end = 1'b1; end
            MODE_INDY:  begin info.kind = AK_IND; info.idx = IX_Y; info.post_idx = 1'b1;
                              info.dummy_end = 1'b1; end
            default:    info.kind = AK_NONE;
        endcase
    end

endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
    import opf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ZP_BASE = 16'h2000
) (
    input  mode_info_t    info,
    input  logic [DW-1:0] x_val,
    input  logic [DW-1:0] y_val,
    input  logic [DW-1:0] byte_in,
    input  logic [DW-1:0] ptr,
    input  logic [AW-1:0] word_in,
    output logic [AW-1:0] zp_eff,
    output logic [AW-1:0] abs_eff,
    output logic [AW-1:0] ptr_lo_addr,
    output logic [AW-1:0] ptr_hi_addr,
    output logic [DW-1:0] ptr_first
);

    logic [DW-1:0] idx, pre, post, zsum, ptr_nx;

    always_comb begin
        unique case (info.idx)
            IX_X:    idx = x_val;
            IX_Y:    idx = y_val;
            default: idx = '0;
        endcase
        pre  = (info.kind == AK_ZP || (info.kind == AK_IND && !info.post_idx)) ? idx : '0;
        post = (info.kind == AK_ABS || (info.kind == AK_IND && info.post_idx)) ? idx : '0;
        zsum      = byte_in + pre;
        ptr_first = byte_in + pre;
        ptr_nx    = ptr + 1'b1;
        zp_eff      = ZP_BASE + AW'(zsum);
        abs_eff     = word_in + AW'(post);
        ptr_lo_addr = ZP_BASE + AW'(ptr);
        ptr_hi_addr = ZP_BASE + AW'(ptr_nx);
    end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
    import opf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ZP_BASE = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     pc_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     y_in,
    input  logic [DW-1:0]     rd_data,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd,
    output logic [AW-1:0]     pc_out,
    output logic              done,
    output logic [AW-1:0]     opnd_a,
    output logic [AW-1:0]     opnd_b,
    output logic [AW-1:0]     opnd_c,
    output logic [DW-1:0]     imm_byte
);

    fsm_e              st, st_nx;
    mode_info_t        info_in, info_r;
    logic [AW-1:0]     pc_r;
    logic [DW-1:0]     x_r, y_r, lo_r, ptr_r, imm_r;
    logic [WIDX_W-1:0] widx;
    logic [AW-1:0]     opnd_q [NWORD];
    logic [AW-1:0]     zp_eff, abs_eff, ptr_lo_addr, ptr_hi_addr;
    logic [DW-1:0]     ptr_first;
    logic              idle_w, accept;

    assign idle_w = (st == ST_IDLE);
    assign accept = idle_w && start;

    opf_mode_dec u_dec (
        .code (mode),
        .info (info_in)
    );

    opf_ea_calc #(.AW(AW), .DW(DW), .ZP_BASE(ZP_BASE)) u_ea (
        .info        (info_r),
        .x_val       (x_r),
        .y_val       (y_r),
        .byte_in     (rd_data),
        .ptr         (ptr_r),
        .word_in     ({rd_data, lo_r}),
        .zp_eff      (zp_eff),
        .abs_eff     (abs_eff),
        .ptr_lo_addr (ptr_lo_addr),
        .ptr_hi_addr (ptr_hi_addr),
        .ptr_first   (ptr_first)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    if (info_in.has_imm)              st_nx = ST_IMMED;
                    else if (info_in.kind == AK_NONE) st_nx = ST_DUMMY;
                    else if (info_in.kind == AK_IND)  st_nx = ST_PTR;
                    else                              st_nx = ST_LO;
                end
            end
            ST_IMMED: st_nx = ST_LO;
            ST_LO: begin
                if (info_r.kind == AK_BYTE)    st_nx = ST_DONE;
                else if (info_r.kind == AK_ZP) st_nx = info_r.dummy_end ? ST_DUMMY : ST_DONE;
                else                           st_nx = ST_HI;
            end
            ST_HI: begin
                if (info_r.kind == AK_BLOCK && widx != WIDX_W'(NWORD - 1)) st_nx = ST_LO;
                else if (info_r.dummy_end)                                 st_nx = ST_DUMMY;
                else                                                       st_nx = ST_DONE;
            end
            ST_PTR:   st_nx = ST_PDUM;
            ST_PDUM:  st_nx = ST_PLO;
            ST_PLO:   st_nx = ST_PHI;
            ST_PHI:   st_nx = ST_DUMMY;
            ST_DUMMY: st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_rd   = 1'b0;
        bus_addr = pc_r;
        done     = 1'b0;
        unique case (st)
            ST_IMMED, ST_LO, ST_HI, ST_PTR, ST_PDUM, ST_DUMMY: bus_rd = 1'b1;
            ST_PLO: begin bus_rd = 1'b1; bus_addr = ptr_lo_addr; end
            ST_PHI: begin bus_rd = 1'b1; bus_addr = ptr_hi_addr; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_r <= '0;
            pc_r   <= '0;
            x_r    <= '0;
            y_r    <= '0;
            lo_r   <= '0;
            ptr_r  <= '0;
            imm_r  <= '0;
            widx   <= '0;
            for (int i = 0; i < NWORD; i++) opnd_q[i] <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        info_r <= info_in;
                        pc_r   <= pc_in;
                        x_r    <= x_in;
                        y_r    <= y_in;
                        imm_r  <= '0;
                        widx   <= '0;
                        for (int i = 0; i < NWORD; i++) opnd_q[i] <= '0;
                    end
                end
                ST_IMMED: begin
                    imm_r <= rd_data;
                    pc_r  <= pc_r + 1'b1;
                end
                ST_LO: begin
                    lo_r <= rd_data;
                    pc_r <= pc_r + 1'b1;
                    if (info_r.kind == AK_BYTE) opnd_q[0] <= AW'(rd_data);
                    if (info_r.kind == AK_ZP)   opnd_q[0] <= zp_eff;
                end
                ST_HI: begin
                    pc_r <= pc_r + 1'b1;
                    if (info_r.kind == AK_ABS) opnd_q[0] <= abs_eff;
                    else                       opnd_q[widx] <= {rd_data, lo_r};
                    widx <= widx + 1'b1;
                end
                ST_PTR: begin
                    ptr_r <= ptr_first;
                    pc_r  <= pc_r + 1'b1;
                end
                ST_PLO: lo_r <= rd_data;
                ST_PHI: opnd_q[0] <= abs_eff;
                default: ;
            endcase
        end
    end

    assign pc_out   = pc_r;
    assign opnd_a   = opnd_q[0];
    assign opnd_b   = opnd_q[1];
    assign opnd_c   = opnd_q[2];
    assign imm_byte = imm_r;

endmodule

// File: rtl/opf_seq_chk.sv
module opf_seq_chk #(
    parameter int AW = 16,
    parameter logic [AW-1:0] ZP_BASE = 16'h2000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          idle,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [AW-1:0] pc_out,
    input logic          done
);

    logic [3:0]    cnt;
    logic [AW-1:0] zoff;

    assign zoff = bus_addr - ZP_BASE;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (start && idle)         cnt <= 4'd1;
        else if (!idle && cnt != 4'hF)  cnt <= cnt + 4'd1;
    end

    // R2: done is a single-cycle pulse
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done arrives 2 to 7 cycles after the accepting edge
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt >= 4'd2 && cnt <= 4'd7));

    // R12: one access per cycle, none while idle or done
    assert_no_access_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle || done) |-> !bus_rd);

    // R12: non-PC reads fall inside the zero page window
    assert_zp_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != pc_out) |-> (zoff < AW'(256)));

    // R12: PC only holds or steps by one between accepted starts
    assert_pc_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && idle) |=> (pc_out == $past(pc_out) || pc_out == $past(pc_out) + 1'b1));

endmodule

bind opfetch_seq opf_seq_chk #(.AW(AW), .ZP_BASE(ZP_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .idle     (idle_w),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .pc_out   (pc_out),
    .done     (done)
);

// File: tb/opfetch_seq_tb_top.sv
module opfetch_seq_tb_top;
    import opf_pkg::*;

    localparam logic [15:0] BASE = 16'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0, y_in = '0, rd_data = '0;
    logic [15:0] bus_addr, pc_out, opnd_a, opnd_b, opnd_c;
    logic        bus_rd, done;
    logic [7:0]  imm_byte;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    opfetch_seq #(.AW(16), .DW(8), .ZP_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .pc_out(pc_out), .done(done), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .opnd_c(opnd_c), .imm_byte(imm_byte)
    );

    // memory model: computed per address, with a small override table
    logic [15:0] ov_addr [8];
    logic [7:0]  ov_data [8];
    int          ov_n = 0;

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] v;
        v = (a[7:0] * 8'h25) ^ a[15:8] ^ 8'h5A;
        for (int i = 0; i < ov_n; i++) if (ov_addr[i] == a) v = ov_data[i];
        return v;
    endfunction

    always @(negedge clk) rd_data <= memf(bus_addr);

    task automatic set_ov(input logic [15:0] a, input logic [7:0] d);
        ov_addr[ov_n] = a;
        ov_data[ov_n] = d;
        ov_n++;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference model state
    logic [15:0] rp;
    int          rn;
    logic [15:0] exp_addr [16];
    logic [15:0] ea, eb, ec;
    logic [7:0]  ei;

    task automatic rd_pc(output logic [7:0] v);
        v = memf(rp);
        exp_addr[rn] = rp;
        rn++;
        rp++;
    endtask

    task automatic rd_at(input logic [15:0] a, output logic [7:0] v);
        v = memf(a);
        exp_addr[rn] = a;
        rn++;
    endtask

    task automatic dum();
        exp_addr[rn] = rp;
        rn++;
    endtask

    task automatic ref_model(input logic [4:0] m, input logic [15:0] pc,
                             input logic [7:0] x, input logic [7:0] y);
        logic [7:0] b, lo, hi, z, ix;
        rp = pc; rn = 0; ea = 0; eb = 0; ec = 0; ei = 0;
        ix = (m == MODE_ZPX || m == MODE_ABSX || m == MODE_IZPX || m == MODE_IABSX) ? x :
             (m == MODE_ZPY || m == MODE_ABSY) ? y : 8'h00;
        case (m)
            MODE_IMPL: dum();
            MODE_IMM: begin rd_pc(b); ea = {8'h00, b}; end
            MODE_ZP, MODE_ZPX, MODE_ZPY: begin
                rd_pc(b); z = b + ix; ea = BASE + {8'h00, z}; dum();
            end
            MODE_ABS, MODE_ABSX, MODE_ABSY: begin
                rd_pc(lo); rd_pc(hi); ea = {hi, lo} + {8'h00, ix}; dum();
            end
            MODE_WORD: begin rd_pc(lo); rd_pc(hi); ea = {hi, lo}; end
            MODE_BLOCK: begin
                rd_pc(lo); rd_pc(hi); ea = {hi, lo};
                rd_pc(lo); rd_pc(hi); eb = {hi, lo};
                rd_pc(lo); rd_pc(hi); ec = {hi, lo};
            end
            MODE_IZP, MODE_IZPX: begin
                rd_pc(ei); rd_pc(b); z = b + ix; ea = BASE + {8'h00, z}; dum();
            end
            MODE_IABS, MODE_IABSX: begin
                rd_pc(ei); rd_pc(lo); rd_pc(hi); ea = {hi, lo} + {8'h00, ix}; dum();
            end
            default: begin
                rd_pc(z); dum();
                if (m == MODE_INDX) z = z + x;
                rd_at(BASE + {8'h00, z}, lo);
                z = z + 8'h01;
                rd_at(BASE + {8'h00, z}, hi);
                dum();
                ea = {hi, lo} + ((m == MODE_INDY) ? {8'h00, y} : 16'h0000);
            end
        endcase
    endtask

    task automatic run_case(input string tag, input logic [4:0] m,
                            input logic [15:0] pc, input logic [7:0] x,
                            input logic [7:0] y, input bit poke);
        logic [15:0] got [16];
        int gn = 0, cyc = 0;
        bit seen = 0;
        ref_model(m, pc, x, y);
        @(negedge clk);
        start = 1'b1; mode = m; pc_in = pc; x_in = x; y_in = y;
        while (!seen && cyc < 20) begin
            @(negedge clk);
            if (cyc == 0) begin
                if (poke) begin
                    mode = MODE_IMPL; pc_in = 16'h1111; x_in = 8'h77; y_in = 8'h77;
                end else start = 1'b0;
            end
            if (cyc == 1) start = 1'b0;
            if (bus_rd && gn < 16) begin got[gn] = bus_addr; gn++; end
            if (done) seen = 1;
            cyc++;
        end
        chk(tag, "done seen", 32'(seen), 32'd1);
        chk(tag, "access count", 32'(gn), 32'(rn));
        for (int i = 0; i < rn && i < gn; i++) chk(tag, "access addr", 32'(got[i]), 32'(exp_addr[i]));
        chk(tag, "opnd_a", 32'(opnd_a), 32'(ea));
        chk(tag, "opnd_b", 32'(opnd_b), 32'(eb));
        chk(tag, "opnd_c", 32'(opnd_c), 32'(ec));
        chk(tag, "imm_byte", 32'(imm_byte), 32'(ei));
        chk(tag, "pc_out", 32'(pc_out), 32'(rp));
    endtask

    task automatic t_reset();
        chk("R1", "bus_rd", 32'(bus_rd), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "pc_out", 32'(pc_out), 32'd0);
        chk("R1", "opnd_a", 32'(opnd_a), 32'd0);
        chk("R1", "opnd_b", 32'(opnd_b), 32'd0);
        chk("R1", "opnd_c", 32'(opnd_c), 32'd0);
        chk("R1", "imm_byte", 32'(imm_byte), 32'd0);
    endtask

    task automatic t_implied();   run_case("R3", MODE_IMPL, 16'h4310, 8'h11, 8'h22, 0); endtask
    task automatic t_immediate(); run_case("R4", MODE_IMM, 16'h8001, 8'h00, 8'h00, 0); endtask

    task automatic t_zero_page();
        ov_n = 0;
        set_ov(16'h5000, 8'hF0);
        run_case("R5", MODE_ZP,  16'h5000, 8'h30, 8'h40, 0);
        run_case("R5", MODE_ZPX, 16'h5000, 8'h30, 8'h40, 0);  // wraps to 0x20
        run_case("R5", MODE_ZPY, 16'h5000, 8'h30, 8'h05, 0);
        ov_n = 0;
    endtask

    task automatic t_absolute();
        ov_n = 0;
        set_ov(16'h6100, 8'hF0); set_ov(16'h6101, 8'hFF);
        run_case("R6", MODE_ABS,  16'h6100, 8'h20, 8'h03, 0);
        run_case("R6", MODE_ABSX, 16'h6100, 8'h20, 8'h03, 0);  // 16-bit wrap
        run_case("R6", MODE_ABSY, 16'h6100, 8'h20, 8'h03, 0);
        ov_n = 0;
    endtask

    task automatic t_word();  run_case("R7", MODE_WORD, 16'h7204, 8'h55, 8'h66, 0); endtask
    task automatic t_block(); run_case("R8", MODE_BLOCK, 16'h9ABC, 8'h00, 8'h00, 0); endtask

    task automatic t_intrusion();
        run_case("R2", MODE_BLOCK, 16'h3330, 8'h10, 8'h20, 1);
        run_case("R2", MODE_INDX, 16'h3400, 8'h10, 8'h20, 1);
    endtask

    task automatic t_imm_test();
        ov_n = 0;
        set_ov(16'h0C01, 8'hE0); set_ov(16'h0C02, 8'hFF);
        run_case("R9", MODE_IZP,   16'h0C00, 8'h30, 8'h00, 0);
        run_case("R9", MODE_IZPX,  16'h0C00, 8'h30, 8'h00, 0);
        run_case("R9", MODE_IABS,  16'h0C00, 8'h30, 8'h00, 0);
        run_case("R9", MODE_IABSX, 16'h0C00, 8'h30, 8'h00, 0);
        ov_n = 0;
    endtask

    task automatic t_indirect();
        ov_n = 0;
        set_ov(16'hA000, 8'h40);
        set_ov(BASE + 16'h0040, 8'hF8); set_ov(BASE + 16'h0041, 8'hFF);
        set_ov(BASE + 16'h0050, 8'h34); set_ov(BASE + 16'h0051, 8'h12);
        run_case("R10", MODE_ZIND, 16'hA000, 8'h10, 8'h09, 0);
        run_case("R10", MODE_INDX, 16'hA000, 8'h10, 8'h09, 0);
        run_case("R10", MODE_INDY, 16'hA000, 8'h10, 8'h09, 0);  // post index wraps
        run_case("R10", MODE_INDX, 16'hA000, 8'hD0, 8'h09, 0);  // pre index wraps to 0x10
        ov_n = 0;
    endtask

    task automatic t_ptr_wrap();
        ov_n = 0;
        set_ov(16'hB000, 8'hFF);
        set_ov(16'hB100, 8'hF0);
        set_ov(BASE + 16'h00FF, 8'h78);
        set_ov(BASE + 16'h0000, 8'h56);
        set_ov(BASE + 16'h0100, 8'hEE);   // decoy beyond the zero page
        run_case("R11", MODE_ZIND, 16'hB000, 8'h00, 8'h00, 0);
        run_case("R11", MODE_INDY, 16'hB000, 8'h00, 8'h02, 0);
        run_case("R11", MODE_INDX, 16'hB100, 8'h0F, 8'h00, 0);
        ov_n = 0;
    endtask

    task automatic t_hold();
        logic [15:0] a0, p0;
        a0 = opnd_a; p0 = pc_out;
        repeat (4) @(negedge clk);
        chk("R2", "opnd_a held", 32'(opnd_a), 32'(a0));
        chk("R2", "pc_out held", 32'(pc_out), 32'(p0));
        chk("R2", "done low while idle", 32'(done), 32'd0);
        chk("R12", "no read while idle", 32'(bus_rd), 32'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_implied();
        t_immediate();
        t_zero_page();
        t_absolute();
        t_word();
        t_block();
        t_hold();
        t_intrusion();
        t_imm_test();
        t_indirect();
        t_ptr_wrap();
        t_hold();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

endmodule